// File: doc/BRIEF.md
# Predicated Floating-Point Minimum Reduction

This block folds the floating-point elements of one vector into a single scalar minimum. A start strobe comes with the vector, a byte-granular predicate, a 2-bit element-size code and two mode bits. Each lane is either kept or replaced by positive infinity, depending on its predicate bit. The lanes are then combined by a fixed binary tree of two-operand minimum nodes. One clock later the block presents the result, zero-extended to 64 bits, together with a one-cycle valid pulse.

The two mode bits pick how a node treats signed zeros and NaNs. In the standard mode, negative zero ranks below positive zero. In that mode a NaN input gives either a propagated quiet NaN or the default NaN, depending on `dflt_nan_i`. In the alternate mode, a pair of zeros or any NaN input gives the node's second operand. Because the tree order is fixed, these rules give a result that can be repeated bit for bit.

Top module: `fp_min_reduce`

## Requirements
- R1: Size code 01 selects 16-bit half, 10 selects 32-bit single and 11 selects 64-bit double elements. Lane i occupies vector bits [i*W +: W], with VEC_W/W lanes. The result sits in the low W bits of `result_o`, and the upper bits are zero.
- R2: Size code 00 is reserved. A start with this code raises `illegal_o` for one cycle and gives no valid pulse. It leaves `result_o` unchanged.
- R3: A lane is active exactly when the predicate bit of its lowest byte (bit i*W/8) is 1. The lane's other predicate bits have no effect.
- R4: An inactive lane enters the tree as positive infinity. With no active lane the result is positive infinity (0x7C00, 0x7F800000 or 0x7FF0000000000000).
- R5: The lanes reduce by a balanced pairwise tree: lanes 2j and 2j+1 meet first, then those results pair in the same way. At every node the lower-indexed side is the first operand.
- R6: With `alt_mode_i`=0, a node returns the numerically smaller operand, and negative zero ranks below positive zero.
- R7: With `alt_mode_i`=0 and `dflt_nan_i`=0, a NaN input gives a quiet NaN. If the first operand is signalling, the result is the first operand quieted (top mantissa bit set). Otherwise, if the second is signalling, it is the second quieted. Otherwise it is the first NaN operand, else the second.
- R8: With `alt_mode_i`=0 and `dflt_nan_i`=1, a NaN input gives the default NaN. This is a positive value with an all-ones exponent and only the top mantissa bit set.
- R9: With `alt_mode_i`=1, two zeros of any sign, or any NaN input, give the second operand unchanged, whatever `dflt_nan_i` is. Otherwise the smaller operand is returned.
- R10: A legal start raises `res_valid_o` for exactly the next cycle, with the registered result. Reset clears `res_valid_o`, `illegal_o` and `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a reduction using the inputs of this cycle |
| vec_i | input | VEC_W | Source vector, lane 0 in the low bits |
| pred_i | input | VEC_W/8 | Predicate, one bit per vector byte |
| esize_i | input | 2 | Element-size code |
| alt_mode_i | input | 1 | Alternate zero/NaN handling in every node |
| dflt_nan_i | input | 1 | Default-NaN output in the standard mode |
| res_valid_o | output | 1 | One-cycle pulse marking a new result |
| illegal_o | output | 1 | One-cycle pulse for a reserved size code |
| result_o | output | 64 | Minimum, zero-extended |

## Verification
The bench builds the block with VEC_W=64. That gives four half, two single and one double lane, and an 8-bit predicate. At this size every one of the 256 predicate patterns can be swept for every element size and all four mode combinations. Lane values are drawn from signed zeros, ones, infinities, quiet and signalling NaNs and random patterns. A small tree with all masks reachable exposes every node-ordering, ignored-predicate-bit and empty-mask case.

// File: rtl/fmin_pkg.sv
// Shared definitions for the predicated floating-point minimum reduction.
// Assumes IEEE-754 binary16/32/64 layouts (sign, exponent, mantissa).
package fmin_pkg;

    typedef enum logic [1:0] {
        SZ_RSVD   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } esize_e;

    localparam int H_EXP = 5;
    localparam int H_MAN = 10;
    localparam int S_EXP = 8;
    localparam int S_MAN = 23;
    localparam int D_EXP = 11;
    localparam int D_MAN = 52;
    localparam int OUT_W = 64;

endpackage

// File: rtl/fmin_node.sv
// Two-operand floating-point minimum, purely combinational.
// a_i is the first operand and b_i the second. alt_i selects alternate handling:
// a pair of zeros or any NaN returns b_i. In the standard mode, NaNs propagate
// quietly, or become the default NaN when dn_i is set.
// Assumes the operand width is 1 + EXP_W + MAN_W and MAN_W >= 2.
module fmin_node #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         alt_i,
    input  logic         dn_i,
    output logic [W-1:0] y_o
);

    localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 1);
    localparam logic [W-1:0] DFLT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic a_nan, b_nan, a_snan, b_snan, a_zero, b_zero, a_lt_b;

    // Classify both operands.
    always_comb begin
        a_nan  = (&a_i[W-2:MAN_W]) && (|a_i[MAN_W-1:0]);
        b_nan  = (&b_i[W-2:MAN_W]) && (|b_i[MAN_W-1:0]);
        a_snan = a_nan && !a_i[MAN_W-1];
        b_snan = b_nan && !b_i[MAN_W-1];
        a_zero = ~|a_i[W-2:0];
        b_zero = ~|b_i[W-2:0];
    end

    // Sign-magnitude ordering in which -0 ranks below +0.
    always_comb begin
        if (a_i[W-1] != b_i[W-1])
            a_lt_b = a_i[W-1];
        else if (a_i[W-1])
            a_lt_b = a_i[W-2:0] > b_i[W-2:0];
        else
            a_lt_b = a_i[W-2:0] < b_i[W-2:0];
    end

    // Select the node output according to the mode bits.
    always_comb begin
        if (alt_i) begin
            if (a_nan || b_nan || (a_zero && b_zero))
                y_o = b_i;
            else
                y_o = a_lt_b ? a_i : b_i;
        end else if (a_nan || b_nan) begin
            if (dn_i)        y_o = DFLT_NAN;
            else if (a_snan) y_o = a_i | QUIET_BIT;
            else if (b_snan) y_o = b_i | QUIET_BIT;
            else if (a_nan)  y_o = a_i;
            else             y_o = b_i;
        end else begin
            y_o = a_lt_b ? a_i : b_i;
        end
    end

endmodule

// File: rtl/fmin_tree.sv
// Masks the lanes of one element format and reduces them with a balanced
// heap-ordered tree of fmin_node instances. Leaf k holds lane k, and node j
// takes child 2j+1 (lower lanes) as first operand and child 2j+2 as second.
// Assumes VEC_W / element width is a power of two.
module fmin_tree #(
    parameter int VEC_W = 256,
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int EW    = 1 + EXP_W + MAN_W,
    localparam int PRED_W = VEC_W / 8
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              alt_i,
    input  logic              dn_i,
    output logic [EW-1:0]     min_o
);

    localparam int N_LANES = VEC_W / EW;
    localparam int LANE_B  = EW / 8;
    localparam int N_NODES = 2 * N_LANES - 1;
    localparam logic [EW-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};

    logic [EW-1:0] nd [N_NODES];

    // Leaves: an active lane passes through, an inactive one becomes +infinity.
    for (genvar i = 0; i < N_LANES; i++) begin : g_leaf
        assign nd[N_LANES-1+i] = pred_i[i*LANE_B] ? vec_i[i*EW +: EW] : POS_INF;
    end

    // Internal nodes in heap order; node 0 is the root.
    for (genvar j = 0; j < N_LANES - 1; j++) begin : g_node
        fmin_node #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_node (
            .a_i   (nd[2*j+1]),
            .b_i   (nd[2*j+2]),
            .alt_i (alt_i),
            .dn_i  (dn_i),
            .y_o   (nd[j])
        );
    end

    assign min_o = nd[0];

endmodule

// File: rtl/fp_min_reduce.sv
// Predicated floating-point minimum reduction over one vector.
// Holds one reduction tree per element format and selects by the size code.
// The chosen result is registered, with a one-cycle valid pulse.
// A reserved size code yields an illegal pulse instead, and the result is held.
// Assumes VEC_W is a power of two and at least 64.
module fp_min_reduce
    import fmin_pkg::*;
#(
    parameter int VEC_W = 256,
    localparam int PRED_W = VEC_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic [1:0]        esize_i,
    input  logic              alt_mode_i,
    input  logic              dflt_nan_i,
    output logic              res_valid_o,
    output logic              illegal_o,
    output logic [63:0]       result_o
);

    logic [15:0]      min_h;
    logic [31:0]      min_s;
    logic [63:0]      min_d;
    logic [OUT_W-1:0] min_sel;
    logic             legal;

    fmin_tree #(.VEC_W(VEC_W), .EXP_W(H_EXP), .MAN_W(H_MAN)) u_tree_h (
        .vec_i(vec_i), .pred_i(pred_i), .alt_i(alt_mode_i), .dn_i(dflt_nan_i), .min_o(min_h));
    fmin_tree #(.VEC_W(VEC_W), .EXP_W(S_EXP), .MAN_W(S_MAN)) u_tree_s (
        .vec_i(vec_i), .pred_i(pred_i), .alt_i(alt_mode_i), .dn_i(dflt_nan_i), .min_o(min_s));
    fmin_tree #(.VEC_W(VEC_W), .EXP_W(D_EXP), .MAN_W(D_MAN)) u_tree_d (
        .vec_i(vec_i), .pred_i(pred_i), .alt_i(alt_mode_i), .dn_i(dflt_nan_i), .min_o(min_d));

    // Pick the tree that matches the size code and zero-extend it.
    always_comb begin
        unique case (esize_e'(esize_i))
            SZ_HALF:   min_sel = OUT_W'(min_h);
            SZ_SINGLE: min_sel = OUT_W'(min_s);
            SZ_DOUBLE: min_sel = min_d;
            default:   min_sel = '0;
        endcase
        legal = esize_e'(esize_i) != SZ_RSVD;
    end

    // Register the result and emit the valid or illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            illegal_o   <= 1'b0;
            result_o    <= '0;
        end else begin
            res_valid_o <= start_i && legal;
            illegal_o   <= start_i && !legal;
            if (start_i && legal)
                result_o <= min_sel;
        end
    end

    a_r10_valid_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(start_i) && $past(esize_i) != 2'b00);

    a_r2_illegal_from_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(start_i) && $past(esize_i) == 2'b00);

    a_r2_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(result_o));

    a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid_o, illegal_o}));

    a_r1_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && $past(esize_i) == 2'b01 |-> result_o[63:16] == '0);

    a_r4_empty_single_inf: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && $past(pred_i) == '0 && $past(esize_i) == 2'b10
        |-> result_o == 64'h0000_0000_7F80_0000);

endmodule

// File: tb/fp_min_reduce_tb.sv
module fp_min_reduce_tb_top;

    localparam int VW = 64;
    localparam int PW = VW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [VW-1:0] vec = '0;
    logic [PW-1:0] pred = '0;
    logic [1:0]    esize = 2'b01;
    logic          alt = 1'b0;
    logic          dn = 1'b0;
    logic          res_valid, illegal;
    logic [63:0]   result;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fp_min_reduce #(.VEC_W(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vec_i(vec), .pred_i(pred),
        .esize_i(esize), .alt_mode_i(alt), .dflt_nan_i(dn),
        .res_valid_o(res_valid), .illegal_o(illegal), .result_o(result));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Format helpers derived from the size code.
    function automatic int f_ew(input logic [1:0] sz);  return 8 << sz; endfunction
    function automatic int f_exp(input logic [1:0] sz);
        return (sz == 2'b01) ? 5 : (sz == 2'b10) ? 8 : 11;
    endfunction
    function automatic logic [63:0] f_mask(input int ew);
        return (ew == 64) ? '1 : ((64'd1 << ew) - 1);
    endfunction

    function automatic bit is_nan(input logic [63:0] x, input logic [1:0] sz);
        int mw = f_ew(sz) - 1 - f_exp(sz);
        logic [63:0] e = (x >> mw) & ((64'd1 << f_exp(sz)) - 1);
        return (e == ((64'd1 << f_exp(sz)) - 1)) && ((x & ((64'd1 << mw) - 1)) != 0);
    endfunction

    // Reference minimum: ordered integer key, smaller key is smaller value.
    function automatic logic [63:0] ref_min(input logic [63:0] a, input logic [63:0] b,
                                            input logic [1:0] sz, input bit am, input bit dnm);
        int ew = f_ew(sz);
        int mw = ew - 1 - f_exp(sz);
        logic [63:0] m = f_mask(ew);
        logic [63:0] sb = 64'd1 << (ew - 1);
        logic [63:0] qb = 64'd1 << (mw - 1);
        logic [63:0] ka, kb;
        bit an = is_nan(a, sz), bn = is_nan(b, sz);
        ka = (a & sb) != 0 ? (~a & m) : (a | sb);
        kb = (b & sb) != 0 ? (~b & m) : (b | sb);
        if (am) begin
            if (an || bn) return b;
            if (((a & ~sb) == 0) && ((b & ~sb) == 0)) return b;
            return (ka < kb) ? a : b;
        end
        if (an || bn) begin
            if (dnm) return (((64'd1 << f_exp(sz)) - 1) << mw) | qb;
            if (an && (a & qb) == 0) return a | qb;
            if (bn && (b & qb) == 0) return b | qb;
            return an ? a : b;
        end
        return (ka < kb) ? a : b;
    endfunction

    function automatic logic [63:0] ref_reduce(input logic [VW-1:0] v, input logic [PW-1:0] p,
                                               input logic [1:0] sz, input bit am, input bit dnm);
        int ew = f_ew(sz);
        int n = VW / ew;
        int mw = ew - 1 - f_exp(sz);
        logic [63:0] l [4];
        for (int i = 0; i < n; i++)
            l[i] = p[i*ew/8] ? ((v >> (i*ew)) & f_mask(ew)) : (((64'd1 << f_exp(sz)) - 1) << mw);
        for (int c = n; c > 1; c = c / 2)
            for (int i = 0; i < c / 2; i++)
                l[i] = ref_min(l[2*i], l[2*i+1], sz, am, dnm);
        return l[0];
    endfunction

    function automatic logic [63:0] pick(input logic [1:0] sz, input int idx);
        int ew = f_ew(sz);
        int xw = f_exp(sz);
        int mw = ew - 1 - xw;
        logic [63:0] bias = (64'd1 << (xw - 1)) - 1;
        logic [63:0] inf = ((64'd1 << xw) - 1) << mw;
        logic [63:0] sb = 64'd1 << (ew - 1);
        case (idx)
            0: return 64'd0;
            1: return sb;
            2: return bias << mw;
            3: return sb | (bias << mw);
            4: return inf;
            5: return sb | inf;
            6: return inf | (64'd1 << (mw - 1)) | 64'd5;
            7: return inf | 64'd3;
            8: return sb | inf | (64'd1 << (mw - 1)) | 64'd9;
            9: return (bias + 1) << mw;
            default: return {$urandom, $urandom} & f_mask(ew);
        endcase
    endfunction

    // Issue one start and check the registered response.
    task automatic run_op(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [1:0] sz,
                          input bit am, input bit dnm, input string tag);
        logic [63:0] exp = ref_reduce(v, p, sz, am, dnm);
        @(negedge clk);
        vec = v; pred = p; esize = sz; alt = am; dn = dnm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(res_valid === 1'b1 && illegal === 1'b0, "R10 valid pulse", {62'd0, res_valid, illegal}, 64'd2);
        chk(result === exp, tag, result, exp);
    endtask

    initial begin
        #(1_500_000ns);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] held;
        logic [VW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid === 1'b0 && illegal === 1'b0 && result === 64'd0, "R10 reset state", result, 64'd0);

        // R5 directed: alternate mode, lanes {qNaN a, qNaN b, 1.0, 2.0}: root gets 1.0.
        run_op({16'h4000, 16'h3C00, 16'h7E02, 16'h7E01}, 8'hFF, 2'b01, 1'b1, 1'b0, "R5 tree order");
        chk(result === 64'h3C00, "R5 tree order value", result, 64'h3C00);
        // R3 directed: only non-leading bytes set, all half lanes inactive.
        run_op({16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00}, 8'hAA, 2'b01, 1'b0, 1'b0, "R3 R4 ignored bits");
        chk(result === 64'h7C00, "R3 R4 empty half inf", result, 64'h7C00);
        // R6 directed: -0 vs +0 in single.
        run_op({32'h0000_0000, 32'h8000_0000}, 8'hFF, 2'b10, 1'b0, 1'b0, "R6 signed zero");
        chk(result === 64'h8000_0000, "R6 negative zero wins", result, 64'h8000_0000);
        @(negedge clk);
        chk(res_valid === 1'b0, "R10 single-cycle pulse", {63'd0, res_valid}, 64'd0);

        // R2: reserved size code.
        held = result;
        @(negedge clk);
        vec = '1; pred = '1; esize = 2'b00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(illegal === 1'b1 && res_valid === 1'b0, "R2 illegal pulse", {62'd0, res_valid, illegal}, 64'd1);
        chk(result === held, "R2 result held", result, held);
        @(negedge clk);
        chk(illegal === 1'b0, "R2 illegal single cycle", {63'd0, illegal}, 64'd0);

        // Sweep all predicates for every size and mode pair (R1 R3 R4 R5 R6 R7 R8 R9).
        for (int sz = 1; sz <= 3; sz++) begin
            for (int md = 0; md < 4; md++) begin
                for (int p = 0; p < 256; p++) begin
                    for (int r = 0; r < 2; r++) begin
                        int ew = f_ew(2'(sz));
                        string tag = md[1] ? "R1 R3 R4 R5 R9 sweep"
                                   : md[0] ? "R1 R3 R4 R5 R6 R8 sweep"
                                           : "R1 R3 R4 R5 R6 R7 sweep";
                        v = '0;
                        for (int i = 0; i < VW / ew; i++)
                            v = v | (VW'(pick(2'(sz), $urandom_range(0, 10))) << (i * ew));
                        run_op(v, 8'(p), 2'(sz), md[1], md[0], tag);
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule